// File: doc/BRIEF.md
# Programmable master/serial clock divider

This block turns one of three reference tick streams (a crystal input and two PLL outputs) into a master clock and a serial bit clock. All of them are modelled as one-cycle enables on a single fast clock. The selected reference goes through three stages in turn. The first is a coarse pre-divider that divides by 2, 2.5 or 3. The second is an integer divide-by-N. The last is a serial divide by 2 or 4. The outputs are one-cycle strobes for the master and serial domains, plus a square wave that toggles on every master strobe so the master rate can be observed.

Software controls the block through one 32-bit configuration register. That register is guarded: a write reaches it only when the write just before it put the unlock key into a separate lock register. The configuration can always be read back. Any accepted configuration write restarts every divider stage from phase zero, so a new ratio begins cleanly.

Top module: `mclk_divider`

## Requirements
- R1: After reset, `cfg_rd` reads zero and no `mclk_stb`, `sclk_stb` or `mclk_sq` activity occurs.
- R2: Configuration bit 1 selects the reference: 0 selects `xtal_tick` and 1 selects a PLL. When a PLL is selected, bit 2 chooses `pll2_tick` when set and `pll1_tick` when clear. Ticks on unselected references have no effect.
- R3: Configuration bits [4:3] hold the pre-divide code. 00 disables the clock, 01 divides by 2, 11 divides by 3. 10 divides by 2.5 using pre-divider periods of 2, 3, 2, 3 ... selected ticks, starting with 2.
- R4: Configuration bits [11:5] hold N, and a value of 0 or 1 means divide by 1. The k-th master strobe after a configuration write comes with the selected tick numbered P(k*N). Here P(m) is 2m, floor(5m/2) or 3m for the pre-divide codes 01, 10 and 11.
- R5: When configuration bit 12 is 1, a serial strobe occurs on every 4th master strobe; when it is 0, on every 2nd. A serial strobe is always in the same cycle as a master strobe.
- R6: While configuration bit 0 (master enable) is 0, no master or serial strobes are produced.
- R7: A write with `wr_sel`=1 and data equal to the unlock key arms the lock. The next write of either kind disarms it. A write with `wr_sel`=0 updates the configuration only if it was armed. A write with the wrong key, or a configuration write that was not armed, leaves `cfg_rd` unchanged.
- R8: Configuration bits [31:13] read as zero whatever is written.
- R9: An accepted configuration write clears all divider phases, so the count of R4 restarts from the next selected tick.
- R10: `mclk_sq` changes value exactly in the cycles in which `mclk_stb` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock for all logic |
| rst_n | input | 1 | Active-low synchronous reset |
| xtal_tick | input | 1 | Crystal reference enable |
| pll1_tick | input | 1 | First PLL reference enable |
| pll2_tick | input | 1 | Second PLL reference enable |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = configuration register, 1 = lock register |
| wr_data | input | 32 | Write data |
| cfg_rd | output | 32 | Current configuration value |
| mclk_stb | output | 1 | Master clock enable strobe, registered |
| sclk_stb | output | 1 | Serial clock enable strobe, registered |
| mclk_sq | output | 1 | Square wave toggling on each master strobe |

## Verification
The hardest case to reach is the divide-by-2.5 phase. It is only correct if the 2/3 alternation restarts with a period of 2 after every accepted write and stays correct across master periods when N is odd. Reaching it means first passing through the lock sequence. The bench therefore writes random configurations through the unlock path, with all three references ticking at random, and counts only the ticks of the source it selected. It checks every master strobe against the closed-form tick number P(k*N). Directed cases cover the divide-by-2.5 code with N of 1 and 3, together with a wrong key, an unarmed write, and an arm that a lock-register write consumes.

// File: rtl/mclk_divider.sv
module mclk_divider #(
  parameter logic [31:0] UNLOCK_KEY = 32'h5A5A_C3C3,
  parameter int          NW         = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xtal_tick,
  input  logic        pll1_tick,
  input  logic        pll2_tick,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  output logic [31:0] cfg_rd,
  output logic        mclk_stb,
  output logic        sclk_stb,
  output logic        mclk_sq
);
  localparam int B_EN   = 0;
  localparam int B_PLL  = 1;
  localparam int B_PSEL = 2;
  localparam int B_PRE  = 3;
  localparam int B_N    = 5;
  localparam int B_SDIV = B_N + NW;
  localparam logic [31:0] CFG_MASK = (32'd1 << (B_SDIV + 1)) - 32'd1;

  logic [31:0]   cfg;
  logic          armed;
  logic [1:0]    pc;
  logic          alt;
  logic [NW-1:0] nc;
  logic [1:0]    sc;

  wire [1:0]    pre    = cfg[B_PRE +: 2];
  wire [NW-1:0] ndiv   = cfg[B_N +: NW];
  wire          cfg_wr = wr_en && !wr_sel && armed;

  wire          src    = cfg[B_PLL] ? (cfg[B_PSEL] ? pll2_tick : pll1_tick) : xtal_tick;
  wire          tick   = cfg[B_EN] && (pre != 2'b00) && src;
  wire [1:0]    plim   = (pre == 2'b11 || (pre == 2'b10 && alt)) ? 2'd2 : 2'd1;
  wire          p_hit  = tick && (pc == plim);
  wire [NW-1:0] nlim   = (ndiv <= NW'(1)) ? '0 : ndiv - NW'(1);
  wire          m_hit  = p_hit && (nc == nlim);
  wire [1:0]    slim   = cfg[B_SDIV] ? 2'd3 : 2'd1;
  wire          s_hit  = m_hit && (sc == slim);

  assign cfg_rd = cfg;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg   <= '0;
      armed <= 1'b0;
    end else if (wr_en) begin
      armed <= wr_sel && (wr_data == UNLOCK_KEY);
      if (cfg_wr) cfg <= wr_data & CFG_MASK;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || cfg_wr) begin
      pc  <= '0;
      alt <= 1'b0;
      nc  <= '0;
      sc  <= '0;
    end else if (tick) begin
      pc <= p_hit ? 2'd0 : pc + 2'd1;
      if (p_hit) begin
        alt <= ~alt;
        nc  <= m_hit ? '0 : nc + NW'(1);
      end
      if (m_hit) sc <= s_hit ? 2'd0 : sc + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mclk_stb <= 1'b0;
      sclk_stb <= 1'b0;
      mclk_sq  <= 1'b0;
    end else begin
      mclk_stb <= m_hit;
      sclk_stb <= s_hit;
      mclk_sq  <= mclk_sq ^ m_hit;
    end
  end
endmodule

// File: rtl/mclk_divider_chk.sv
module mclk_divider_chk #(
  parameter int NW = 7
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        wr_sel,
  input logic        armed,
  input logic [31:0] cfg_rd,
  input logic        mclk_stb,
  input logic        sclk_stb,
  input logic        mclk_sq
);
  localparam int RSV_LO = NW + 6;

  p_idle_when_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_rd[0] |=> !mclk_stb && !sclk_stb);

  p_idle_when_pre_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_rd[4:3] == 2'b00) |=> !mclk_stb);

  p_serial_inside_master_r5: assert property (@(posedge clk) disable iff (!rst_n)
    sclk_stb |-> mclk_stb);

  p_unarmed_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_sel && !armed |=> $stable(cfg_rd));

  p_lock_write_keeps_cfg_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel |=> $stable(cfg_rd));

  p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rd[31:RSV_LO] == '0);

  p_square_follows_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
    mclk_stb == (mclk_sq != $past(mclk_sq)));
endmodule

bind mclk_divider mclk_divider_chk #(.NW(NW)) chk_i (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .armed(armed),
  .cfg_rd(cfg_rd), .mclk_stb(mclk_stb), .sclk_stb(sclk_stb), .mclk_sq(mclk_sq)
);

// File: tb/mclk_divider_tb_top.sv
module mclk_divider_tb_top;
  localparam logic [31:0] KEY = 32'h5A5A_C3C3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xtal_tick = 1'b0, pll1_tick = 1'b0, pll2_tick = 1'b0;
  logic wr_en = 1'b0, wr_sel = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] cfg_rd;
  logic mclk_stb, sclk_stb, mclk_sq;

  always #10 clk = ~clk;

  mclk_divider dut_i (.*);

  int checks = 0, fails = 0, cycles = 0;
  logic [31:0] m_cfg = '0;
  int ticks, mcnt, scnt;
  logic prev_sq;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual cycles=%0d expected <150000", cycles);
      summary();
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int neff(input logic [31:0] c);
    return (c[11:5] <= 7'd1) ? 1 : int'(c[11:5]);
  endfunction

  function automatic int pexp(input logic [1:0] pre, input int m);
    case (pre)
      2'b01:   return 2 * m;
      2'b10:   return (5 * m) / 2;
      default: return 3 * m;
    endcase
  endfunction

  function automatic bit running(input logic [31:0] c);
    return c[0] && (c[4:3] != 2'b00);
  endfunction

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [31:0] d);
    xtal_tick = 0; pll1_tick = 0; pll2_tick = 0;
    wr_en = 1; wr_sel = sel; wr_data = d;
    cyc();
    wr_en = 0;
  endtask

  task automatic restart_model();
    ticks = 0; mcnt = 0; scnt = 0; prev_sq = mclk_sq;
  endtask

  task automatic cfg_write(input logic [31:0] v);
    wr(1'b1, KEY);
    wr(1'b0, v);
    m_cfg = v & 32'h0000_1FFF;
    chk(cfg_rd == m_cfg, "R7 armed write", cfg_rd, m_cfg);
    restart_model();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      logic sel;
      xtal_tick = 1'($urandom); pll1_tick = 1'($urandom); pll2_tick = 1'($urandom);
      sel = m_cfg[1] ? (m_cfg[2] ? pll2_tick : pll1_tick) : xtal_tick;
      cyc();
      if (running(m_cfg) && sel) ticks++;
      if (!running(m_cfg)) begin
        chk(!mclk_stb && !sclk_stb, "R6/R3 no strobe when off", {mclk_stb, sclk_stb}, 0);
      end else begin
        if (mclk_stb) begin
          mcnt++;
          chk(ticks == pexp(m_cfg[4:3], mcnt * neff(m_cfg)), "R4/R3/R2/R9 master tick",
              ticks, pexp(m_cfg[4:3], mcnt * neff(m_cfg)));
        end
        if (sclk_stb) begin
          scnt++;
          chk(mclk_stb && (mcnt == scnt * (m_cfg[12] ? 4 : 2)), "R5 serial strobe",
              mcnt, scnt * (m_cfg[12] ? 4 : 2));
        end
      end
      chk((mclk_sq != prev_sq) == mclk_stb, "R10 square toggle", mclk_sq, mclk_stb ^ prev_sq);
      prev_sq = mclk_sq;
    end
    if (running(m_cfg)) begin
      chk(pexp(m_cfg[4:3], (mcnt + 1) * neff(m_cfg)) > ticks, "R4 no missed master strobe",
          ticks, pexp(m_cfg[4:3], (mcnt + 1) * neff(m_cfg)));
      chk(scnt == mcnt / (m_cfg[12] ? 4 : 2), "R5 serial count", scnt, mcnt / (m_cfg[12] ? 4 : 2));
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    restart_model();
    repeat (3) cyc();
    rst_n = 1;
    @(negedge clk);
    chk(cfg_rd == 0, "R1 reset config", cfg_rd, 0);
    run(50);
    chk(mcnt == 0 && mclk_sq == 0, "R1 idle after reset", mcnt, 0);

    wr(1'b0, 32'h0000_0009);
    chk(cfg_rd == 0, "R7 unarmed write ignored", cfg_rd, 0);
    wr(1'b1, KEY ^ 32'h1);
    wr(1'b0, 32'h0000_0009);
    chk(cfg_rd == 0, "R7 wrong key ignored", cfg_rd, 0);
    wr(1'b1, KEY);
    wr(1'b1, 32'h0);
    wr(1'b0, 32'h0000_0009);
    chk(cfg_rd == 0, "R7 arm consumed by lock write", cfg_rd, 0);

    cfg_write(32'hFFFF_FFFF);
    chk(cfg_rd[31:13] == 0, "R8 reserved bits zero", cfg_rd[31:13], 0);
    run(400);

    cfg_write(32'h0000_0008 | (32'd1 << 5));
    run(200);
    cfg_write(32'h0000_0000 | 32'h0000_0010 | (32'd3 << 5));
    run(200);
    chk(mcnt == 0, "R6 disabled gives no strobes", mcnt, 0);
    cfg_write(32'h0000_0001 | (32'd5 << 5));
    run(200);
    chk(mcnt == 0, "R3 code 00 gives no strobes", mcnt, 0);

    cfg_write(32'h0000_0011 | (32'd1 << 5));
    run(300);
    cfg_write(32'h0000_1017 | (32'd3 << 5));
    run(400);
    cfg_write(32'h0000_0019 | (32'd0 << 5));
    run(300);
    cfg_write(32'h0000_0003 | 32'h0000_0008 | (32'd4 << 5));
    run(150);
    cfg_write(32'h0000_0013 | (32'd3 << 5));
    run(300);

    for (int it = 0; it < 60; it++) begin
      logic [31:0] v;
      v = $urandom;
      v[0] = 1'b1;
      if (v[4:3] == 2'b00) v[4:3] = 2'b10;
      v[11:5] = 7'($urandom_range(0, 9));
      cfg_write(v);
      run(400);
    end

    summary();
  end
endmodule